// File: doc/BRIEF.md
# Selectable Victim Way Picker

This block names the way of an N-way set that should be replaced when a cache miss needs room. For every set it holds replacement state, and it offers three ways of choosing among occupied ways: a pseudo-random choice, a true least-recently-used choice and a first-in-first-out choice. A static mode input picks the policy. Whatever the policy, an empty way in the addressed set is always taken first. The tag and data arrays live outside this block.

The surrounding cache controller presents the set index together with that set's valid bits, and reads the victim way back in the same cycle. A hit strobe with the hitting way refreshes the recency order. A fill strobe states that the line is written into the way shown on the victim output in that cycle, and the block updates its per-set state to match.

Top module: `repl_victim_sel`

## Requirements
- R1: When any bit of `way_valid` is 0, `victim_way` is the lowest-numbered way whose valid bit is 0, in every mode.
- R2: The `mode` encoding is 0 = random, 1 = LRU, 2 = FIFO, and 3 = random (same behaviour as 0).
- R3: The random source is a 16-bit register reset to 16'hACE1 that steps on every clock edge out of reset: it shifts left by one, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. With all ways valid in random mode, `victim_way` equals the low log2(WAYS) bits of its current value.
- R4: In LRU mode with all ways valid, `victim_way` is the way whose rank is WAYS-1 (the oldest). Reset gives way w rank w in every set, so the first LRU victim of a set is way WAYS-1.
- R5: On a touch of way t in set `set_idx`, way t takes rank 0, every way of that set with a rank lower than t's old rank gains one, and the other ways keep their rank. A hit (`hit_en` with `hit_way`) and a fill both count as touches.
- R6: A fill writes the way shown on `victim_way` in that cycle. When `fill_en` and `hit_en` are both high, only the fill touches the LRU order and the hit is dropped.
- R7: Each set has a FIFO pointer reset to 0. In FIFO mode with all ways valid, `victim_way` is the pointer. The pointer steps by one, wrapping to 0, on each fill of that set, and hits leave it unchanged.
- R8: Updates change only the state of the set given by `set_idx`. All other sets keep their state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Policy select, held static during operation |
| set_idx | input | log2(SETS) | Set being looked up or updated |
| way_valid | input | WAYS | Valid bits of the addressed set, bit w for way w |
| hit_en | input | 1 | Access hit strobe |
| hit_way | input | log2(WAYS) | Way that hit |
| fill_en | input | 1 | Fill strobe; the fill goes to `victim_way` |
| victim_way | output | log2(WAYS) | Way to evict |

## Verification
On every cycle, the assertions check the following. Free-way priority and lowest-index selection hold. The random register never becomes zero and shifts as a shift register should. The ranks of the addressed set stay a permutation. A touched way sits at rank 0 one cycle later. LRU ranks and FIFO pointers do not move unless there is a hit or a fill. Only the bench's scenarios can show that the victim order is right over a sequence of accesses. These scenarios cover aging after hits and fills, the fill-over-hit precedence, FIFO wraparound and the fact that hits do not affect it, isolation between sets, the exact random sequence after reset, and the return to reset state after a mid-run reset.

// File: rtl/repl_pkg.sv
package repl_pkg;

   typedef enum logic [1:0] {
      RP_RAND     = 2'd0,
      RP_LRU      = 2'd1,
      RP_FIFO     = 2'd2,
      RP_RAND_ALT = 2'd3
   } repl_mode_e;

   localparam int unsigned RAND_W = 16;

   // one step of the maximal-length sequence, polynomial x^16+x^14+x^13+x^11+1
   function automatic logic [RAND_W-1:0] rand_step(input logic [RAND_W-1:0] s);
      return {s[RAND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

endpackage

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
   parameter int unsigned              OUT_W = 2,
   parameter logic [repl_pkg::RAND_W-1:0] SEED  = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd_o
);
   import repl_pkg::*;

   generate
      if (SEED == '0) begin : g_bad_seed
         $error("repl_lfsr: seed must be nonzero");
      end
      if (OUT_W > RAND_W) begin : g_bad_width
         $error("repl_lfsr: output wider than state");
      end
   endgenerate

   logic [RAND_W-1:0] state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEED;
      else        state_q <= rand_step(state_q);
   end

   assign rnd_o = state_q[OUT_W-1:0];

   AST_RAND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0); // R3
   AST_RAND_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> state_q[RAND_W-1:1] == $past(state_q[RAND_W-2:0])); // R3

endmodule

// File: rtl/repl_free_pick.sv
module repl_free_pick #(
   parameter int unsigned WAYS = 4,
   localparam int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  valid_i,
   output logic             any_free_o,
   output logic [WAY_W-1:0] free_way_o
);
   always_comb begin
      any_free_o = ~&valid_i;
      free_way_o = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!valid_i[w]) free_way_o = WAY_W'(w);
      end
   end
endmodule

// File: rtl/repl_lru_bank.sv
module repl_lru_bank #(
   parameter int unsigned WAYS = 4,
   parameter int unsigned SETS = 16,
   localparam int unsigned WAY_W = $clog2(WAYS),
   localparam int unsigned SET_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_i,
   input  logic             touch_en_i,
   input  logic [WAY_W-1:0] touch_way_i,
   output logic [WAY_W-1:0] oldest_o
);
   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

   logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] rank_q;
   logic [WAYS-1:0][WAY_W-1:0]           row;
   logic [WAYS-1:0][WAY_W-1:0]           row_nxt;
   logic [WAY_W-1:0]                     old_rank;

   assign row      = rank_q[set_i];
   assign old_rank = row[touch_way_i];

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_age
         assign row_nxt[w] = (WAY_W'(w) == touch_way_i) ? '0 :
                             (row[w] < old_rank)        ? row[w] + WAY_W'(1) :
                                                          row[w];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               rank_q[s][w] <= WAY_W'(w);
            end
         end
      end else if (touch_en_i) begin
         rank_q[set_i] <= row_nxt;
      end
   end

   always_comb begin
      oldest_o = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (row[w] == OLDEST) oldest_o = WAY_W'(w);
      end
   end

   // ---- checking aids ----
   logic [WAYS-1:0]  rank_seen;
   logic             last_vld_q;
   logic [SET_W-1:0] last_set_q;
   logic [WAY_W-1:0] last_way_q;

   always_comb begin
      rank_seen = '0;
      for (int w = 0; w < WAYS; w++) rank_seen[row[w]] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_vld_q <= 1'b0;
         last_set_q <= '0;
         last_way_q <= '0;
      end else begin
         last_vld_q <= touch_en_i;
         last_set_q <= set_i;
         last_way_q <= touch_way_i;
      end
   end

   AST_LRU_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
      &rank_seen); // R5
   AST_LRU_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
      last_vld_q |-> rank_q[last_set_q][last_way_q] == '0); // R5
   AST_LRU_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !touch_en_i |=> $stable(rank_q)); // R8

endmodule

// File: rtl/repl_fifo_bank.sv
module repl_fifo_bank #(
   parameter int unsigned WAYS = 4,
   parameter int unsigned SETS = 16,
   localparam int unsigned WAY_W = $clog2(WAYS),
   localparam int unsigned SET_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_i,
   input  logic             adv_i,
   output logic [WAY_W-1:0] ptr_o
);
   logic [SETS-1:0][WAY_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_q         <= '0;
      else if (adv_i) ptr_q[set_i]  <= ptr_q[set_i] + WAY_W'(1);
   end

   assign ptr_o = ptr_q[set_i];

   AST_FIFO_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(ptr_q)); // R7

endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel #(
   parameter int unsigned WAYS = 4,
   parameter int unsigned SETS = 16,
   parameter logic [15:0] SEED = 16'hACE1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                mode,
   input  logic [$clog2(SETS)-1:0]   set_idx,
   input  logic [WAYS-1:0]           way_valid,
   input  logic                      hit_en,
   input  logic [$clog2(WAYS)-1:0]   hit_way,
   input  logic                      fill_en,
   output logic [$clog2(WAYS)-1:0]   victim_way
);
   import repl_pkg::*;

   localparam int unsigned WAY_W = $clog2(WAYS);
   localparam int unsigned SET_W = $clog2(SETS);

   generate
      if (!(WAYS == 2 || WAYS == 4 || WAYS == 8)) begin : g_bad_ways
         $error("repl_victim_sel: WAYS must be 2, 4 or 8");
      end
      if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
         $error("repl_victim_sel: SETS must be a power of two, at least 2");
      end
   endgenerate

   repl_mode_e       pol;
   logic             any_free;
   logic [WAY_W-1:0] free_way;
   logic [WAY_W-1:0] rnd_way;
   logic [WAY_W-1:0] lru_way;
   logic [WAY_W-1:0] fifo_way;
   logic             touch_en;
   logic [WAY_W-1:0] touch_way;

   assign pol = repl_mode_e'(mode);

   repl_free_pick #(.WAYS(WAYS)) u_free (
      .valid_i    (way_valid),
      .any_free_o (any_free),
      .free_way_o (free_way)
   );

   repl_lfsr #(.OUT_W(WAY_W), .SEED(SEED)) u_rand (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd_o (rnd_way)
   );

   repl_lru_bank #(.WAYS(WAYS), .SETS(SETS)) u_lru (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (set_idx),
      .touch_en_i  (touch_en),
      .touch_way_i (touch_way),
      .oldest_o    (lru_way)
   );

   repl_fifo_bank #(.WAYS(WAYS), .SETS(SETS)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_idx),
      .adv_i (fill_en),
      .ptr_o (fifo_way)
   );

   always_comb begin
      if (any_free) begin
         victim_way = free_way;
      end else begin
         unique case (pol)
            RP_LRU:  victim_way = lru_way;
            RP_FIFO: victim_way = fifo_way;
            default: victim_way = rnd_way;
         endcase
      end
   end

   // fill wins over a simultaneous hit
   assign touch_en  = fill_en | hit_en;
   assign touch_way = fill_en ? victim_way : hit_way;

   function automatic logic [WAYS-1:0] below(input logic [WAY_W-1:0] w);
      logic [WAYS-1:0] m;
      for (int i = 0; i < WAYS; i++) m[i] = (WAY_W'(i) < w);
      return m;
   endfunction

   AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      !(&way_valid) |-> !way_valid[victim_way]); // R1
   AST_FREE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      !(&way_valid) |-> (way_valid & below(victim_way)) == below(victim_way)); // R1

endmodule

// File: tb/tb_repl_victim_sel.sv
module tb_repl_victim_sel;
   localparam int WAYS = 4;
   localparam int SETS = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd1;
   logic [3:0] set_idx = '0;
   logic [3:0] way_valid = 4'hF;
   logic       hit_en = 1'b0;
   logic [1:0] hit_way = '0;
   logic       fill_en = 1'b0;
   logic [1:0] victim_way;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   repl_victim_sel #(.WAYS(WAYS), .SETS(SETS)) dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .set_idx(set_idx),
      .way_valid(way_valid), .hit_en(hit_en), .hit_way(hit_way),
      .fill_en(fill_en), .victim_way(victim_way)
   );

   // reference random sequence built from R3
   logic [15:0] ref_rnd;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) ref_rnd <= 16'hACE1;
      else        ref_rnd <= {ref_rnd[14:0], ref_rnd[15] ^ ref_rnd[13] ^ ref_rnd[12] ^ ref_rnd[10]};
   end

   // vector: {mode[15:14], set[13:10], valid[9:6], hit[5], hit_way[4:3], fill[2], expected[1:0]}
   localparam int NV = 29;
   localparam logic [15:0] VEC [NV] = '{
      {2'd1, 4'd3,  4'hF,    1'b1, 2'd1, 1'b0, 2'd3},
      {2'd1, 4'd3,  4'hF,    1'b1, 2'd3, 1'b0, 2'd3},
      {2'd1, 4'd3,  4'hF,    1'b0, 2'd0, 1'b0, 2'd2},
      {2'd1, 4'd3,  4'hF,    1'b1, 2'd2, 1'b0, 2'd2},
      {2'd1, 4'd5,  4'hF,    1'b0, 2'd0, 1'b0, 2'd3},
      {2'd1, 4'd3,  4'hF,    1'b0, 2'd0, 1'b1, 2'd0},
      {2'd1, 4'd3,  4'hF,    1'b1, 2'd2, 1'b1, 2'd1},
      {2'd1, 4'd3,  4'hF,    1'b0, 2'd0, 1'b0, 2'd3},
      {2'd1, 4'd3,  4'hF,    1'b1, 2'd0, 1'b0, 2'd3},
      {2'd1, 4'd3,  4'hF,    1'b0, 2'd0, 1'b0, 2'd3},
      {2'd2, 4'd7,  4'hF,    1'b0, 2'd0, 1'b0, 2'd0},
      {2'd2, 4'd7,  4'hF,    1'b1, 2'd0, 1'b0, 2'd0},
      {2'd2, 4'd7,  4'hF,    1'b0, 2'd0, 1'b0, 2'd0},
      {2'd2, 4'd7,  4'hF,    1'b0, 2'd0, 1'b1, 2'd0},
      {2'd2, 4'd7,  4'hF,    1'b0, 2'd0, 1'b1, 2'd1},
      {2'd2, 4'd7,  4'hF,    1'b1, 2'd2, 1'b0, 2'd2},
      {2'd2, 4'd7,  4'hF,    1'b0, 2'd0, 1'b1, 2'd2},
      {2'd2, 4'd7,  4'hF,    1'b0, 2'd0, 1'b1, 2'd3},
      {2'd2, 4'd7,  4'hF,    1'b0, 2'd0, 1'b0, 2'd0},
      {2'd1, 4'd9,  4'b1010, 1'b0, 2'd0, 1'b0, 2'd0},
      {2'd1, 4'd9,  4'b1011, 1'b0, 2'd0, 1'b0, 2'd2},
      {2'd1, 4'd9,  4'b0111, 1'b0, 2'd0, 1'b0, 2'd3},
      {2'd2, 4'd7,  4'b1101, 1'b0, 2'd0, 1'b0, 2'd1},
      {2'd0, 4'd7,  4'b1110, 1'b0, 2'd0, 1'b0, 2'd0},
      {2'd2, 4'd11, 4'b0000, 1'b0, 2'd0, 1'b1, 2'd0},
      {2'd2, 4'd11, 4'b0001, 1'b0, 2'd0, 1'b1, 2'd1},
      {2'd2, 4'd11, 4'b0011, 1'b0, 2'd0, 1'b1, 2'd2},
      {2'd2, 4'd11, 4'b0111, 1'b0, 2'd0, 1'b1, 2'd3},
      {2'd2, 4'd11, 4'hF,    1'b0, 2'd0, 1'b0, 2'd0}
   };

   function automatic string req_of(input int i);
      if (i == 4)             return "R8 set isolation";
      if (i == 5)             return "R4 LRU oldest";
      if (i == 6 || i == 7)   return "R6 fill over hit";
      if (i <= 9)             return "R5 LRU aging";
      if (i <= 12)            return "R7 FIFO hit ignored";
      if (i <= 18)            return "R7 FIFO order";
      if (i <= 23)            return "R1 free way first";
      return "R7 FIFO fill of free ways";
   endfunction

   task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: victim_way=%0d expected=%0d", req, got, exp);
      end
   endtask

   task automatic drive(input logic [1:0] m, input logic [3:0] s, input logic [3:0] v,
                        input logic h, input logic [1:0] hw, input logic f);
      mode = m; set_idx = s; way_valid = v; hit_en = h; hit_way = hw; fill_en = f;
   endtask

   task automatic check_reset_state();
      drive(2'd1, 4'd3, 4'hF, 1'b0, 2'd0, 1'b0);
      #2 check("R4 reset LRU victim", victim_way, 2'd3);
      drive(2'd2, 4'd7, 4'hF, 1'b0, 2'd0, 1'b0);
      #1 check("R7 reset FIFO pointer", victim_way, 2'd0);
      drive(2'd0, 4'd7, 4'hF, 1'b0, 2'd0, 1'b0);
      #1 check("R3 reset random seed", victim_way, 2'd1);
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      hit_en = 1'b0; fill_en = 1'b0; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check_reset_state();

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i][15:14], VEC[i][13:10], VEC[i][9:6], VEC[i][5], VEC[i][4:3], VEC[i][2]);
         #2 check(req_of(i), victim_way, VEC[i][1:0]);
      end

      // random policy: mode 0 then mode 3
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         drive(2'd0, 4'd0, 4'hF, 1'b0, 2'd0, 1'b0);
         #2 check("R3 random sequence", victim_way, ref_rnd[1:0]);
      end
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         drive(2'd3, 4'd0, 4'hF, 1'b0, 2'd0, 1'b0);
         #2 check("R2 mode 3 is random", victim_way, ref_rnd[1:0]);
      end

      // disturb state, then reset mid-run
      @(negedge clk);
      drive(2'd1, 4'd3, 4'hF, 1'b1, 2'd3, 1'b0);
      @(negedge clk);
      drive(2'd1, 4'd3, 4'hF, 1'b0, 2'd0, 1'b0);
      #2 check("R5 hit moves oldest", victim_way, 2'd2);
      @(negedge clk);
      drive(2'd2, 4'd7, 4'hF, 1'b0, 2'd0, 1'b1);
      @(negedge clk);
      drive(2'd2, 4'd7, 4'hF, 1'b0, 2'd0, 1'b0);
      #2 check("R7 fill steps pointer", victim_way, 2'd1);
      pulse_reset();
      check_reset_state();

      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run incomplete, actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule